// File: doc/BRIEF.md
# Multichannel FIR Matrix Multiply Engine

This block computes one column of a matrix product C = A × B per pass. It reuses a multichannel FIR multiply-accumulate datapath for this. Each row of A is held as the tap set of one channel in an internal data memory, stored row after row. The columns of B are held one after another in a coefficient memory. The coefficient base address selects which column of B the current pass uses.

A host programs the tap count, the channel count and the coefficient base while the engine is disabled. It then enables the engine and streams the elements of A into the input register in row-major order. For each channel the engine then forms the sum of products of that channel's taps with the selected column. It returns these sums one by one through the output register, channel 0 first.

To obtain the next column of C, the host disables the engine, moves the coefficient base on by the row count of B, enables the engine again and feeds A once more. The engine reports a 16-bit status word with four flags: output full, input full, memory contention and saturation.

Top module: `fir_matmul`

## Requirements
- R1: After reset the status word, the output register and both full flags read zero.
- R2: Within one pass the results leave in channel order 0, 1, … up to the last channel, one result per channel, and the pass then stops.
- R3: Operands are signed 24-bit fractions with 23 fraction bits. Each result is the sum over taps t of data[ch*len + t] × coef[base + t], where the data words are taken in the order they were written during the pass.
- R4: The tap count register (select 1) holds the tap count minus one. The channel count register (select 2) holds the channel count minus one. Shapes from 1×1 up to the parameter maxima are supported.
- R5: Writing all zeros to the control word (select 0) disables the engine. A write with bit 0 set enables a disabled engine. While the engine is enabled, writes to the tap count, channel count and base (select 3) registers are ignored.
- R6: Writing a new base while the engine is disabled makes the next pass use the coefficients that start at that address.
- R7: Status bit 15 sets when a result is placed in the output register. The result and the flag stay unchanged until the output register is read; the read clears the flag, and only then is the next result presented.
- R8: A write to the input register while it is full and not being drained is ignored. The pending word is kept, and it becomes the first data word of the next pass.
- R9: Each result is rounded and clipped to 24 bits, to 0x7FFFFF or 0x800000. Status bit 12 sets when clipping occurs and stays set until the engine is disabled.
- R10: Status bit 13 sets when a coefficient write arrives while a sum is being computed. It stays set until the engine is disabled.
- R11: Status bit 14 reads 1 while the input register holds a word that has not been consumed.
- R12: Rounding adds half an output LSB before truncation, so an exact half rounds toward plus infinity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 control, 1 tap count−1, 2 channel count−1, 3 coefficient base |
| reg_wdata | input | 24 | Register write data |
| status | output | 16 | Bit 15 output full, 14 input full, 13 contention, 12 saturation, 0 enabled |
| in_we | input | 1 | Input register write strobe |
| in_data | input | 24 | Operand word of matrix A |
| out_rd | input | 1 | Output register read strobe |
| out_data | output | 24 | Result element of C |
| coef_we | input | 1 | Coefficient memory write strobe |
| coef_addr | input | 6 | Coefficient memory address |
| coef_wdata | input | 24 | Coefficient word of matrix B |

## Verification
The bench builds the engine with its defaults: 24-bit words, up to 8 taps, up to 4 channels and a 64-word coefficient memory. These values allow the full 2×3 by 3×4 product, a 1×1 case and a four-channel case. They also allow an 8-tap sum that lasts long enough to place a coefficient write inside it. A width of 24 bits allows directed overflow in both directions and exact half-LSB rounding cases, whose results the bench works out from the fraction format.

// File: rtl/mm_pkg.sv
package mm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_MAC,
    ST_RES,
    ST_PUSH,
    ST_DONE
  } mm_state_e;

  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_LEN  = 2'd1;
  localparam logic [1:0] SEL_CHAN = 2'd2;
  localparam logic [1:0] SEL_BASE = 2'd3;

  localparam int BIT_OFULL = 15;
  localparam int BIT_IFULL = 14;
  localparam int BIT_CONT  = 13;
  localparam int BIT_SAT   = 12;

endpackage

// File: rtl/mm_ram.sv
module mm_ram #(
  parameter int W     = 24,
  parameter int DEPTH = 32,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/mm_mac.sv
module mm_mac #(
  parameter int DW = 24,
  parameter int TW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          vld,
  input  logic          first,
  input  logic          last,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic          done,
  output logic [DW-1:0] res,
  output logic          sat
);

  localparam int AW = 2 * DW + TW + 1;
  localparam logic signed [AW-1:0] HI = {{(AW-DW+1){1'b0}}, {(DW-1){1'b1}}};
  localparam logic signed [AW-1:0] LO = ~HI;

  logic signed [2*DW-1:0] prod;
  logic signed [AW-1:0]   acc_q;
  logic signed [AW-1:0]   rnd;
  logic signed [AW-1:0]   sh;
  logic                   over, under;

  assign prod = $signed(a) * $signed(b);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      done  <= 1'b0;
    end else begin
      done <= vld && last;
      if (vld) acc_q <= (first ? '0 : acc_q) + AW'(prod);
    end
  end

  assign rnd   = acc_q + (AW'(1) <<< (DW - 2));
  assign sh    = rnd >>> (DW - 1);
  assign over  = sh > HI;
  assign under = sh < LO;
  assign sat   = over || under;
  assign res   = over ? HI[DW-1:0] : (under ? LO[DW-1:0] : sh[DW-1:0]);

  // R3
  done_after_last_chk: assert property (@(posedge clk) disable iff (rst)
    vld && last |=> done);

endmodule

// File: rtl/fir_matmul.sv
module fir_matmul
  import mm_pkg::*;
#(
  parameter int DW         = 24,
  parameter int MAX_TAPS   = 8,
  parameter int MAX_CH     = 4,
  parameter int COEF_DEPTH = 64,
  parameter int CAW        = $clog2(COEF_DEPTH)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           reg_we,
  input  logic [1:0]     reg_sel,
  input  logic [DW-1:0]  reg_wdata,
  output logic [15:0]    status,
  input  logic           in_we,
  input  logic [DW-1:0]  in_data,
  input  logic           out_rd,
  output logic [DW-1:0]  out_data,
  input  logic           coef_we,
  input  logic [CAW-1:0] coef_addr,
  input  logic [DW-1:0]  coef_wdata
);

  localparam int TW  = $clog2(MAX_TAPS);
  localparam int CHW = $clog2(MAX_CH);
  localparam int DAW = $clog2(MAX_TAPS * MAX_CH);
  localparam logic [DW-1:0] MAXV = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] MINV = {1'b1, {(DW-1){1'b0}}};

  mm_state_e      state_q;
  logic           en_q, sat_q, cont_q, in_full_q, out_full_q;
  logic [TW-1:0]  len_m1_q, tap_q;
  logic [CHW-1:0] chm1_q, ch_q;
  logic [CAW-1:0] cbase_q;
  logic [DAW-1:0] wptr_q, rbase_q;
  logic [DW-1:0]  in_reg_q, out_q;
  logic           vld_q, first_q, last_q;
  logic           take, load_last, busy;
  logic [DW-1:0]  d_rdata, c_rdata, mac_res;
  logic           mac_done, mac_sat;

  assign take      = (state_q == ST_LOAD) && in_full_q;
  assign load_last = int'(wptr_q) == (int'(len_m1_q) + 1) * (int'(chm1_q) + 1) - 1;
  assign busy      = (state_q == ST_MAC) || (state_q == ST_RES) || (state_q == ST_PUSH);

  mm_ram #(.W(DW), .DEPTH(MAX_TAPS * MAX_CH), .AW(DAW)) u_dmem (
    .clk   (clk),
    .we    (take),
    .waddr (wptr_q),
    .wdata (in_reg_q),
    .raddr (rbase_q + DAW'(tap_q)),
    .rdata (d_rdata)
  );

  mm_ram #(.W(DW), .DEPTH(COEF_DEPTH), .AW(CAW)) u_cmem (
    .clk   (clk),
    .we    (coef_we),
    .waddr (coef_addr),
    .wdata (coef_wdata),
    .raddr (cbase_q + CAW'(tap_q)),
    .rdata (c_rdata)
  );

  mm_mac #(.DW(DW), .TW(TW)) u_mac (
    .clk   (clk),
    .rst   (rst),
    .vld   (vld_q),
    .first (first_q),
    .last  (last_q),
    .a     (d_rdata),
    .b     (c_rdata),
    .done  (mac_done),
    .res   (mac_res),
    .sat   (mac_sat)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      en_q       <= 1'b0;
      sat_q      <= 1'b0;
      cont_q     <= 1'b0;
      in_full_q  <= 1'b0;
      out_full_q <= 1'b0;
      len_m1_q   <= '0;
      chm1_q     <= '0;
      cbase_q    <= '0;
      tap_q      <= '0;
      ch_q       <= '0;
      wptr_q     <= '0;
      rbase_q    <= '0;
      in_reg_q   <= '0;
      out_q      <= '0;
      vld_q      <= 1'b0;
      first_q    <= 1'b0;
      last_q     <= 1'b0;
    end else begin
      vld_q <= 1'b0;

      // input register
      if (in_we && (!in_full_q || take)) begin
        in_reg_q  <= in_data;
        in_full_q <= 1'b1;
      end else if (take) begin
        in_full_q <= 1'b0;
      end

      if (out_rd) out_full_q <= 1'b0;
      if (coef_we && busy) cont_q <= 1'b1;

      unique case (state_q)
        ST_LOAD: if (take) begin
          wptr_q <= wptr_q + DAW'(1);
          if (load_last) begin
            state_q <= ST_MAC;
            tap_q   <= '0;
            ch_q    <= '0;
            rbase_q <= '0;
          end
        end
        ST_MAC: begin
          vld_q   <= 1'b1;
          first_q <= (tap_q == '0);
          last_q  <= (tap_q == len_m1_q);
          if (tap_q == len_m1_q) state_q <= ST_RES;
          else tap_q <= tap_q + TW'(1);
        end
        ST_RES: if (mac_done) state_q <= ST_PUSH;
        ST_PUSH: if (!out_full_q) begin
          out_q      <= mac_res;
          out_full_q <= 1'b1;
          if (mac_sat) sat_q <= 1'b1;
          if (ch_q == chm1_q) begin
            state_q <= ST_DONE;
          end else begin
            ch_q    <= ch_q + CHW'(1);
            tap_q   <= '0;
            rbase_q <= rbase_q + DAW'(len_m1_q) + DAW'(1);
            state_q <= ST_MAC;
          end
        end
        default: ;
      endcase

      // register writes come last so a disable overrides the sequencer
      if (reg_we) begin
        unique case (reg_sel)
          SEL_CTRL: begin
            if (reg_wdata == '0) begin
              en_q    <= 1'b0;
              state_q <= ST_IDLE;
              sat_q   <= 1'b0;
              cont_q  <= 1'b0;
            end else if (reg_wdata[0] && !en_q) begin
              en_q    <= 1'b1;
              state_q <= ST_LOAD;
              wptr_q  <= '0;
            end
          end
          SEL_LEN:  if (!en_q) len_m1_q <= reg_wdata[TW-1:0];
          SEL_CHAN: if (!en_q) chm1_q   <= reg_wdata[CHW-1:0];
          SEL_BASE: if (!en_q) cbase_q  <= reg_wdata[CAW-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    status            = '0;
    status[BIT_OFULL] = out_full_q;
    status[BIT_IFULL] = in_full_q;
    status[BIT_CONT]  = cont_q;
    status[BIT_SAT]   = sat_q;
    status[0]         = en_q;
  end

  assign out_data = out_q;

  // R7
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    out_full_q && !out_rd |=> out_full_q && $stable(out_q));

  // R8
  in_keep_chk: assert property (@(posedge clk) disable iff (rst)
    in_full_q && !take && in_we |=> $stable(in_reg_q));

  // R5
  base_lock_chk: assert property (@(posedge clk) disable iff (rst)
    en_q |=> $stable(cbase_q) && $stable(len_m1_q) && $stable(chm1_q));

  // R9
  sat_value_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sat_q) |-> (out_q == MAXV || out_q == MINV));

  // R2
  ch_range_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> ch_q <= chm1_q);

endmodule

// File: tb/fir_matmul_test.sv
module fir_matmul_test;

  logic        clk = 1'b0;
  logic        rst;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_sel = '0;
  logic [23:0] reg_wdata = '0;
  logic [15:0] status;
  logic        in_we = 1'b0;
  logic [23:0] in_data = '0;
  logic        out_rd = 1'b0;
  logic [23:0] out_data;
  logic        coef_we = 1'b0;
  logic [5:0]  coef_addr = '0;
  logic [23:0] coef_wdata = '0;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  logic [23:0] amat [32];
  logic [23:0] bmem [64];

  always #10 clk = ~clk;

  fir_matmul uut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .status(status), .in_we(in_we), .in_data(in_data), .out_rd(out_rd),
    .out_data(out_data), .coef_we(coef_we), .coef_addr(coef_addr), .coef_wdata(coef_wdata)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL R2 watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [23:0] calc(input int row, input int len, input int base);
    longint s = 0;
    longint r;
    for (int t = 0; t < len; t++)
      s += longint'($signed(amat[row*len+t])) * longint'($signed(bmem[base+t]));
    r = (s + (64'sd1 <<< 22)) >>> 23;
    if (r > 64'sd8388607) r = 64'sd8388607;
    if (r < -64'sd8388608) r = -64'sd8388608;
    return r[23:0];
  endfunction

  task automatic wr_reg(input logic [1:0] sel, input logic [23:0] val);
    @(negedge clk); reg_we = 1'b1; reg_sel = sel; reg_wdata = val;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic put(input logic [23:0] val);
    @(negedge clk); in_we = 1'b1; in_data = val;
    @(negedge clk); in_we = 1'b0;
  endtask

  task automatic wr_coef(input int a, input logic [23:0] v);
    @(negedge clk); coef_we = 1'b1; coef_addr = 6'(a); coef_wdata = v;
    @(negedge clk); coef_we = 1'b0;
    bmem[a] = v;
  endtask

  task automatic get(input logic [23:0] exp, input string tag);
    int n = 0;
    logic [23:0] v;
    while (!status[15] && n < 2000) begin @(negedge clk); n++; end
    check(status[15] == 1'b1, {tag, " output ready"}, {23'd0, status[15]}, 24'd1);
    v = out_data;
    check(v == exp, tag, v, exp);
    @(negedge clk); @(negedge clk);
    check(status[15] && out_data == v, "R7 result held until read", out_data, v);
    out_rd = 1'b1;
    @(negedge clk); out_rd = 1'b0;
    check(status[15] == 1'b0, "R7 read clears full", {23'd0, status[15]}, 24'd0);
  endtask

  task automatic setup(input int len, input int ch, input int base);
    wr_reg(2'd0, 24'd0);
    wr_reg(2'd1, 24'(len - 1));
    wr_reg(2'd2, 24'(ch - 1));
    wr_reg(2'd3, 24'(base));
    wr_reg(2'd0, 24'd1);
  endtask

  task automatic do_pass(input int len, input int ch, input int base, input bit poke, input string tag);
    setup(len, ch, base);
    if (poke) wr_reg(2'd3, 24'(base + 7));
    for (int i = 0; i < len * ch; i++) put(amat[i]);
    for (int r = 0; r < ch; r++) get(calc(r, len, base), tag);
  endtask

  task automatic t_reset;
    check(status == 16'h0000, "R1 status after reset", {8'd0, status}, 24'd0);
    check(out_data == 24'd0, "R1 output after reset", out_data, 24'd0);
  endtask

  task automatic t_matrix;
    logic [23:0] bv [12] = '{24'h123456, 24'h654321, 24'h0ABCDE, 24'h7FFFFF, 24'h800000, 24'h111111,
                             24'hF00000, 24'h0F0000, 24'h00F000, 24'h333333, 24'hCCCCCD, 24'h555555};
    logic [23:0] av [6] = '{24'h400000, 24'h200000, 24'hC00000, 24'h100000, 24'hE00000, 24'h300000};
    for (int i = 0; i < 12; i++) wr_coef(i, bv[i]);
    for (int i = 0; i < 6; i++) amat[i] = av[i];
    do_pass(3, 2, 0, 1'b0, "R2 R3 column 1");
    do_pass(3, 2, 3, 1'b1, "R5 R6 column 2 base locked");
    do_pass(3, 2, 6, 1'b0, "R6 column 3");
    do_pass(3, 2, 9, 1'b0, "R6 column 4");
  endtask

  task automatic t_dims;
    amat[0] = 24'h5A5A5A;
    do_pass(1, 1, 4, 1'b0, "R4 1x1 shape");
    for (int i = 0; i < 8; i++) amat[i] = 24'(24'h080000 * (i + 1)) ^ 24'h0000F1;
    do_pass(2, 4, 1, 1'b0, "R4 R2 four channels");
  endtask

  task automatic t_round;
    wr_coef(40, 24'h400000);
    amat[0] = 24'h000001; do_pass(1, 1, 40, 1'b0, "R12 half rounds up");
    check(calc(0, 1, 40) == 24'd1, "R12 model half", calc(0, 1, 40), 24'd1);
    amat[0] = 24'hFFFFFF; do_pass(1, 1, 40, 1'b0, "R12 negative half");
    amat[0] = 24'h000003; do_pass(1, 1, 40, 1'b0, "R12 one and a half");
  endtask

  task automatic t_sat;
    wr_coef(44, 24'h7FFFFF); wr_coef(45, 24'h7FFFFF);
    wr_coef(46, 24'h800000); wr_coef(47, 24'h800000);
    amat[0] = 24'h7FFFFF; amat[1] = 24'h7FFFFF;
    do_pass(2, 1, 44, 1'b0, "R9 clip high");
    check(status[12] == 1'b1, "R9 sat flag set", {23'd0, status[12]}, 24'd1);
    amat[0] = 24'h800000; amat[1] = 24'h800000;
    do_pass(2, 1, 44, 1'b0, "R9 clip low");
    check(status[12] == 1'b1, "R9 sat flag low", {23'd0, status[12]}, 24'd1);
    do_pass(2, 1, 46, 1'b0, "R9 minus one squared");
    wr_reg(2'd0, 24'd0);
    check(status[12] == 1'b0, "R9 disable clears sat", {23'd0, status[12]}, 24'd0);
  endtask

  task automatic t_infull;
    wr_coef(50, 24'h200000); wr_coef(51, 24'h400000);
    amat[0] = 24'h100000; amat[1] = 24'h100000;
    do_pass(2, 1, 50, 1'b0, "R3 short pass");
    put(24'h300000);
    check(status[14] == 1'b1, "R11 input full shown", {23'd0, status[14]}, 24'd1);
    put(24'h7F0000);
    wr_reg(2'd0, 24'd0);
    wr_reg(2'd0, 24'd1);
    @(negedge clk);
    check(status[14] == 1'b0, "R11 pending word consumed", {23'd0, status[14]}, 24'd0);
    put(24'h080000);
    amat[0] = 24'h300000; amat[1] = 24'h080000;
    get(calc(0, 2, 50), "R8 write while full ignored");
  endtask

  task automatic t_cont;
    for (int i = 0; i < 8; i++) begin
      wr_coef(20 + i, 24'(24'h010203 * (i + 3)));
      amat[i] = 24'(24'h0F0F0F - 24'h030000 * i);
    end
    setup(8, 1, 20);
    check(status[13] == 1'b0, "R10 no contention yet", {23'd0, status[13]}, 24'd0);
    for (int i = 0; i < 8; i++) put(amat[i]);
    wr_coef(63, 24'h123123);
    check(status[13] == 1'b1, "R10 contention flagged", {23'd0, status[13]}, 24'd1);
    get(calc(0, 8, 20), "R3 eight taps");
    wr_reg(2'd0, 24'd0);
    check(status[13] == 1'b0, "R10 disable clears", {23'd0, status[13]}, 24'd0);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) bmem[i] = '0;
    for (int i = 0; i < 32; i++) amat[i] = '0;
    rst = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset;
    t_matrix;
    t_dims;
    t_round;
    t_sat;
    t_infull;
    t_cont;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule